// File: doc/BRIEF.md
# Zig-Zag Scan Quantizer for 8x8 Transform Blocks

This block takes one 8x8 block of signed transform coefficients, presented all at once on a wide parallel bus, and streams the quantized coefficients out in zig-zag order. The order runs from the lowest spatial frequency to the highest, so the zero-valued high-frequency terms gather at the end of the stream. A small sequencer walks the 64 scan positions and picks the matching coefficient out of a register bank. Each coefficient is divided by a power of two that stands in for its step size, using a rounding shift. There is no quantization table memory, no coefficient RAM and no reorder buffer.

The producer pulses a load strobe while the block is idle. One cycle later the block starts emitting one result per clock for 64 clocks. Each result carries its scan index and marks for the first and final entries. A downstream entropy coder consumes the stream directly.

Top module: `zz_quant`

## Requirements
- R1: While reset is asserted and after its release with no load, `out_valid` and `busy` are 0.
- R2: A load sampled while `busy` is 0 is accepted. On the next clock `busy` is 1 and `out_valid` is 0. Results then appear on 64 consecutive clocks, the first of them on the clock after that.
- R3: Across a block, `out_idx` counts 0 to 63 in steps of one. `out_first` is 1 only with index 0, and `out_last` is 1 only with index 63.
- R4: Coefficient at row r, column c (both 0..7) sits at `in_coef[(8*r+c)*10 +: 10]`. Result index k carries the k-th position of a diagonal scan: diagonals d=r+c are taken in increasing order; within an odd d the row rises, within an even d the row falls.
- R5: The step size of row-major position p is entry p of this list, row by row: 16 11 10 16 24 40 51 61 / 12 12 14 19 26 58 60 55 / 14 13 16 24 40 57 69 56 / 14 17 22 29 51 87 80 62 / 18 22 37 56 68 109 103 77 / 24 35 55 64 81 104 113 92 / 49 64 78 87 103 121 120 101 / 72 92 95 98 112 100 103 99. The divisor is 2^s, with s the power of two nearest the step size; when two powers are equally near, the smaller one is used.
- R6: Division rounds half away from zero and treats signs symmetrically: result = sign(x) * floor((|x| + 2^(s-1)) / 2^s). For example, with s=3, 4 gives 1, -4 gives -1, 3 gives 0 and -3 gives 0.
- R7: `busy` is 1 from the clock after an accepted load through the clock before the final result. It is 0 in the clock that shows the result with index 63.
- R8: A load raised while `busy` is 1 is ignored. The running block completes with its original coefficients, and no new block starts after it.
- R9: A load raised in the clock that shows index 63 is accepted. Its first result follows two clocks later.
- R10: The extreme inputs 511 and -512 quantize without wrap-around. For example, -512 with s=3 gives -64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_load | input | 1 | Load strobe for a new block |
| in_coef | input | 640 | 64 signed 10-bit coefficients, row-major |
| busy | output | 1 | Block in progress; loads ignored |
| out_valid | output | 1 | Result present this clock |
| out_idx | output | 6 | Zig-zag scan index of the result |
| out_first | output | 1 | Result is index 0 (DC term) |
| out_last | output | 1 | Result is index 63 |
| out_data | output | 10 | Signed quantized coefficient |

## Verification
Let E0 be the clock edge that samples an accepted load. `busy` rises at E0. The result with index k is registered at edge E0+1+k, so index 63 lands at E0+64, where `busy` falls. The bench changes inputs and reads outputs on falling edges only. Before the stream it confirms `busy` without `out_valid` at E0. It then reads exactly one result per falling edge, comparing index, marks, data and `busy` against its own model. After an ignored load it takes one further sample to confirm that nothing restarted. For back-to-back blocks it holds the next load through the edge after the final result and expects index 0 two samples later.

// File: rtl/zzq_pkg.sv
package zzq_pkg;

    localparam int unsigned SIDE   = 8;
    localparam int unsigned NPOS   = SIDE * SIDE;
    localparam int unsigned IDX_W  = $clog2(NPOS);
    localparam int unsigned SH_W   = 3;
    localparam int unsigned MAXSH  = (1 << SH_W) - 1;

    // luminance step sizes, row-major
    localparam int unsigned STEP_TBL [NPOS] = '{
        16, 11, 10, 16, 24, 40, 51, 61,
        12, 12, 14, 19, 26, 58, 60, 55,
        14, 13, 16, 24, 40, 57, 69, 56,
        14, 17, 22, 29, 51, 87, 80, 62,
        18, 22, 37, 56, 68, 109, 103, 77,
        24, 35, 55, 64, 81, 104, 113, 92,
        49, 64, 78, 87, 103, 121, 120, 101,
        72, 92, 95, 98, 112, 100, 103, 99
    };

    // nearest power of two exponent, ties to the lower one
    function automatic int unsigned near_pow2(input int unsigned step);
        int unsigned best;
        int unsigned best_err;
        int unsigned err;
        int unsigned pw;
        best     = 0;
        best_err = (step > 1) ? step - 1 : 1 - step;
        for (int unsigned k = 1; k <= MAXSH; k++) begin
            pw  = 1 << k;
            err = (step > pw) ? step - pw : pw - step;
            if (err < best_err) begin
                best     = k;
                best_err = err;
            end
        end
        return best;
    endfunction

    // row-major position for each scan index, packed
    function automatic logic [NPOS*IDX_W-1:0] scan_build();
        logic [NPOS*IDX_W-1:0] tbl;
        int unsigned r;
        int unsigned c;
        tbl = '0;
        r   = 0;
        c   = 0;
        for (int unsigned k = 0; k < NPOS; k++) begin
            tbl[k*IDX_W +: IDX_W] = IDX_W'(r * SIDE + c);
            if (((r + c) % 2) == 0) begin
                if (c == SIDE - 1)  r = r + 1;
                else if (r == 0)    c = c + 1;
                else begin          r = r - 1; c = c + 1; end
            end else begin
                if (r == SIDE - 1)  c = c + 1;
                else if (c == 0)    r = r + 1;
                else begin          r = r + 1; c = c - 1; end
            end
        end
        return tbl;
    endfunction

    // shift amount for each scan index, packed
    function automatic logic [NPOS*SH_W-1:0] shift_build();
        logic [NPOS*IDX_W-1:0] scan;
        logic [NPOS*SH_W-1:0]  tbl;
        int unsigned p;
        scan = scan_build();
        tbl  = '0;
        for (int unsigned k = 0; k < NPOS; k++) begin
            p = int'(scan[k*IDX_W +: IDX_W]);
            tbl[k*SH_W +: SH_W] = SH_W'(near_pow2(STEP_TBL[p]));
        end
        return tbl;
    endfunction

    localparam logic [NPOS*IDX_W-1:0] SCAN_POS = scan_build();
    localparam logic [NPOS*SH_W-1:0]  SCAN_SH  = shift_build();

endpackage

// File: rtl/zzq_bank.sv
module zzq_bank #(
    parameter int unsigned COEF_W = 10,
    parameter int unsigned NUM    = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap,
    input  logic [NUM*COEF_W-1:0]   din,
    output logic [NUM*COEF_W-1:0]   dout
);

    logic [NUM*COEF_W-1:0] bank_d;
    logic [NUM*COEF_W-1:0] bank_q;

    always_comb begin
        bank_d = bank_q;
        if (cap) begin
            bank_d = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign dout = bank_q;

endmodule

// File: rtl/zzq_seq.sv
module zzq_seq #(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    output logic             cap,
    output logic             run,
    output logic [IDX_W-1:0] cnt
);

    localparam logic [IDX_W-1:0] CNT_END = {IDX_W{1'b1}};

    typedef struct packed {
        logic             run;
        logic [IDX_W-1:0] cnt;
    } seq_t;

    seq_t s_d;
    seq_t s_q;

    assign cap = load & ~s_q.run;

    always_comb begin
        s_d = s_q;
        if (!s_q.run) begin
            if (load) begin
                s_d.run = 1'b1;
                s_d.cnt = '0;
            end
        end else if (s_q.cnt == CNT_END) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run = s_q.run;
    assign cnt = s_q.cnt;

endmodule

// File: rtl/zzq_shround.sv
module zzq_shround #(
    parameter int unsigned COEF_W = 10,
    parameter int unsigned SH_W   = 3
) (
    input  logic signed [COEF_W-1:0] din,
    input  logic        [SH_W-1:0]   sh,
    output logic signed [COEF_W-1:0] dout
);

    logic              neg;
    logic [COEF_W-1:0] mag;
    logic [COEF_W:0]   half;
    logic [COEF_W:0]   sum;
    logic [COEF_W:0]   shifted;
    logic [COEF_W-1:0] q;

    always_comb begin
        neg  = din[COEF_W-1];
        mag  = neg ? (~din + 1'b1) : din;
        half = '0;
        if (sh != '0) begin
            half = (COEF_W+1)'(1) << (sh - 1'b1);
        end
        sum     = {1'b0, mag} + half;
        shifted = sum >> sh;
        q       = shifted[COEF_W-1:0];
        dout    = neg ? (~q + 1'b1) : q;
    end

endmodule

// File: rtl/zz_quant.sv
module zz_quant
    import zzq_pkg::*;
#(
    parameter int unsigned COEF_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_load,
    input  logic [NPOS*COEF_W-1:0]   in_coef,
    output logic                     busy,
    output logic                     out_valid,
    output logic [IDX_W-1:0]         out_idx,
    output logic                     out_first,
    output logic                     out_last,
    output logic signed [COEF_W-1:0] out_data
);

    localparam logic [IDX_W-1:0] IDX_END = {IDX_W{1'b1}};

    typedef struct packed {
        logic                     valid;
        logic [IDX_W-1:0]         idx;
        logic                     first;
        logic                     last;
        logic signed [COEF_W-1:0] data;
    } res_t;

    logic                     cap;
    logic                     run;
    logic [IDX_W-1:0]         cnt;
    logic [NPOS*COEF_W-1:0]   bank;
    logic [IDX_W-1:0]         pos;
    logic [SH_W-1:0]          sh;
    logic signed [COEF_W-1:0] sel;
    logic signed [COEF_W-1:0] qv;
    res_t                     r_d;
    res_t                     r_q;

    zzq_seq #(.IDX_W(IDX_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (in_load),
        .cap   (cap),
        .run   (run),
        .cnt   (cnt)
    );

    zzq_bank #(.COEF_W(COEF_W), .NUM(NPOS)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .din   (in_coef),
        .dout  (bank)
    );

    always_comb begin
        pos = SCAN_POS[int'(cnt)*IDX_W +: IDX_W];
        sh  = SCAN_SH[int'(cnt)*SH_W +: SH_W];
        sel = bank[int'(pos)*COEF_W +: COEF_W];
    end

    zzq_shround #(.COEF_W(COEF_W), .SH_W(SH_W)) u_rnd (
        .din   (sel),
        .sh    (sh),
        .dout  (qv)
    );

    always_comb begin
        r_d       = '0;
        r_d.valid = run;
        if (run) begin
            r_d.idx   = cnt;
            r_d.first = (cnt == '0);
            r_d.last  = (cnt == IDX_END);
            r_d.data  = qv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = run;
    assign out_valid = r_q.valid;
    assign out_idx   = r_q.idx;
    assign out_first = r_q.first;
    assign out_last  = r_q.last;
    assign out_data  = r_q.data;

endmodule

// File: rtl/zzq_chk.sv
module zzq_chk #(
    parameter int unsigned IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_load,
    input logic             busy,
    input logic             out_valid,
    input logic [IDX_W-1:0] out_idx,
    input logic             out_first,
    input logic             out_last
);

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_load && !busy) |=> (busy && !out_valid));

    p_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (out_valid && out_first && out_idx == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> busy);

    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> !busy);

    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_load && out_valid && !out_last) |=> !out_first);

endmodule

bind zz_quant zzq_chk #(.IDX_W(zzq_pkg::IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_load   (in_load),
    .busy      (busy),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_first (out_first),
    .out_last  (out_last)
);

// File: tb/sim_zz_quant.sv
`timescale 1ns/1ps
module sim_zz_quant;

    localparam int W = 10;
    localparam int N = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_load = 1'b0;
    logic [N*W-1:0] in_coef = '0;
    logic           busy;
    logic           out_valid;
    logic [5:0]     out_idx;
    logic           out_first;
    logic           out_last;
    logic [W-1:0]   out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int lum [N] = '{
        16, 11, 10, 16, 24, 40, 51, 61,
        12, 12, 14, 19, 26, 58, 60, 55,
        14, 13, 16, 24, 40, 57, 69, 56,
        14, 17, 22, 29, 51, 87, 80, 62,
        18, 22, 37, 56, 68, 109, 103, 77,
        24, 35, 55, 64, 81, 104, 113, 92,
        49, 64, 78, 87, 103, 121, 120, 101,
        72, 92, 95, 98, 112, 100, 103, 99
    };
    int order [N];
    int blk [N];
    int nxt [N];

    always #10 clk = ~clk;

    zz_quant u0 (
        .clk(clk), .rst_n(rst_n), .in_load(in_load), .in_coef(in_coef),
        .busy(busy), .out_valid(out_valid), .out_idx(out_idx),
        .out_first(out_first), .out_last(out_last), .out_data(out_data)
    );

    function automatic int shift_of(input int step);
        int k;
        k = 0;
        while ((1 << (k + 1)) <= step) k++;
        if (step - (1 << k) > (1 << (k + 1)) - step) k++;
        return k;
    endfunction

    function automatic int ref_q(input int x, input int s);
        int m;
        int q;
        if (s == 0) return x;
        m = (x < 0) ? -x : x;
        q = (m + (1 << (s - 1))) >>> s;
        return (x < 0) ? -q : q;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic drive_load(input int v [N]);
        for (int p = 0; p < N; p++) in_coef[p*W +: W] = W'(v[p]);
        in_load = 1'b1;
        @(negedge clk);
        in_load = 1'b0;
    endtask

    // called right after the negedge that follows the load edge
    task automatic run_stream(input int v [N], input bit inject, input string name);
        int e;
        int p;
        check(busy == 1'b1, {name, " R2/R7 busy after load"}, busy, 1);
        check(out_valid == 1'b0, {name, " R2 no result at load edge"}, out_valid, 0);
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            in_load = 1'b0;
            p = order[k];
            e = ref_q(v[p], shift_of(lum[p]));
            check(out_valid == 1'b1, {name, " R2 valid"}, out_valid, 1);
            check(int'(out_idx) == k, {name, " R3 index"}, int'(out_idx), k);
            check(out_first == (k == 0), {name, " R3 first flag"}, out_first, (k == 0));
            check(out_last == (k == N - 1), {name, " R3 last flag"}, out_last, (k == N - 1));
            check(int'($signed(out_data)) == e, {name, " R4/R5/R6 data"}, int'($signed(out_data)), e);
            check(busy == (k != N - 1), {name, " R7 busy"}, busy, (k != N - 1));
            if (inject && k == 10) begin
                for (int q = 0; q < N; q++) in_coef[q*W +: W] = W'(q * 7 - 200);
                in_load = 1'b1;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
    endtask

    task automatic t_ramp();
        for (int p = 0; p < N; p++) blk[p] = p * 8 - 256;
        drive_load(blk);
        run_stream(blk, 0, "ramp R4");
        @(negedge clk);
        check(out_valid == 1'b0, "ramp R2 stream ends", out_valid, 0);
    endtask

    task automatic t_extreme();
        for (int p = 0; p < N; p++) blk[p] = (p % 2) ? 511 : -512;
        drive_load(blk);
        run_stream(blk, 0, "extreme R10");
        @(negedge clk);
    endtask

    task automatic t_halfway();
        int s;
        int h;
        for (int p = 0; p < N; p++) begin
            s = shift_of(lum[p]);
            h = (1 << (s - 1)) - ((p % 4 >= 2) ? 1 : 0);
            blk[p] = (p % 2) ? -h : h;
        end
        drive_load(blk);
        run_stream(blk, 0, "halfway R6");
        @(negedge clk);
    endtask

    task automatic t_busy_load();
        int seed;
        seed = 12345;
        for (int p = 0; p < N; p++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            blk[p] = ((seed >> 8) % 1024) - 512;
        end
        drive_load(blk);
        run_stream(blk, 1, "busyload R8");
        @(negedge clk);
        check(out_valid == 1'b0, "R8 no restart valid", out_valid, 0);
        check(busy == 1'b0, "R8 no restart busy", busy, 0);
    endtask

    task automatic t_chain();
        for (int p = 0; p < N; p++) begin
            blk[p] = (p == 0) ? 300 : 0;
            nxt[p] = 100 - p * 3;
        end
        drive_load(blk);
        run_stream(blk, 0, "chainA R9");
        drive_load(nxt);
        run_stream(nxt, 0, "chainB R9");
        @(negedge clk);
        check(out_valid == 1'b0, "R9 chain ends", out_valid, 0);
    endtask

    initial begin
        int k;
        k = 0;
        for (int d = 0; d <= 14; d++) begin
            int lo;
            int hi;
            lo = (d > 7) ? d - 7 : 0;
            hi = (d < 7) ? d : 7;
            if (d % 2) begin
                for (int r = lo; r <= hi; r++) begin order[k] = r * 8 + d - r; k++; end
            end else begin
                for (int r = hi; r >= lo; r--) begin order[k] = r * 8 + d - r; k++; end
            end
        end
        t_reset();
        t_ramp();
        t_extreme();
        t_halfway();
        t_busy_load();
        t_chain();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule